// File: doc/BRIEF.md
# Keypad Controller Serial Register Target

This block is the host-facing side of a keypad scanning controller. It is an I2C target that watches the oversampled clock and data lines and acknowledges one of four 7-bit addresses, picked by a two-bit strap input. It holds six writable control registers and exposes a seventh, read-only location through which the host drains a key-event queue kept outside the block.

A write transaction sends the address, then a command byte. The command byte becomes the register pointer. Any further bytes are written at the pointer. A read transaction, usually placed behind a repeated START, returns bytes starting at the pointer. After every data byte the pointer moves by a per-register rule:
- On the queue location it stays put, so the host can drain events back to back.
- On the last register it wraps to the queue location.
- Elsewhere it advances by one.

Each byte read from the queue location sends a one-cycle pop strobe to the queue. A bus-timeout watchdog returns a stalled transaction to idle. A configuration bit can turn it off.

Top module: `kp_host_if`

## Requirements
- R1: The target address is {4'b0111, strap_i, 1'b0}: 0x38, 0x3A, 0x3C or 0x3E for strap_i = 0, 1, 2, 3. An address byte with any other 7-bit address gets no acknowledge, and sda_oe_o stays low until the next START.
- R2: In a write transaction, the byte after the address is acknowledged and loaded into the 8-bit register pointer. A following read transaction starts at that pointer.
- R3: After each data byte, written or read, the pointer moves as follows: 0x00 stays 0x00, 0x06 goes to 0x00, 0x01 to 0x05 go up by one, and any other value is left unchanged.
- R4: After reset the registers at 0x01 to 0x06 hold 0x0A, 0xFF, 0x00, 0xFE, 0x00 and 0x07. They appear on cfg_o, dbnc_o, irq_o, port_o, rpt_o and sleep_o. Reading location 0x00 returns evt_data_i, which holds the queue's empty code 0x3F at start-up. Locations 0x07 to 0xFF read as 0x00.
- R5: Location 0x00 is read-only. A write to it is acknowledged but changes no register output, and the pointer stays at 0x00.
- R6: Bits 6, 4 and 2 of the configuration register (0x01) always read as 0, whatever is written. The other bits store the written value.
- R7: Each byte read from location 0x00 gives exactly one one-cycle pulse on evt_pop_o, after the byte's eighth bit. Reads of other locations give no pulse.
- R8: When the host answers a read byte with NACK, the target releases SDA and drives nothing more until the next START.
- R9: A repeated START restarts address reception at once. A STOP returns the target to idle, so bytes clocked after a STOP and before a START get no acknowledge.
- R10: While bit 0 of the configuration register is 0, a transaction with no SCL or SDA edge for TIMEOUT_CYC clock cycles returns the target to idle. While the bit is 1, no such return happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 2 | Address strap: 0 ground, 1 supply, 2 data line, 3 clock line |
| evt_data_i | input | 8 | Head entry of the key-event queue |
| evt_pop_o | output | 1 | One-cycle request to remove the queue head |
| cfg_o | output | 8 | Configuration register (0x01) |
| dbnc_o | output | 8 | Debounce and port-enable register (0x02) |
| irq_o | output | 8 | Interrupt setup register (0x03) |
| port_o | output | 8 | Output port levels register (0x04) |
| rpt_o | output | 8 | Key repeat register (0x05) |
| sleep_o | output | 8 | Idle-to-sleep register (0x06) |

## Verification
A wrong pointer shows up within one byte: the next byte read or written lands at the wrong location, and the matching register output or read value differs in that same transaction. A state machine that loses its bit position shows up in the ninth clock of the byte, as a missing or misplaced acknowledge. A pop strobe given on a non-queue read, or given twice, shows up at once in the queue head value of the next byte. A timeout fault shows up as a byte that is acknowledged when it should not be, or the reverse, right after the stall.

// File: rtl/kp_host_pkg.sv
package kp_host_pkg;

  localparam int NREG = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_LO, ST_ACK_HI, ST_CMD, ST_WDATA,
    ST_RD, ST_RD_END, ST_MACK, ST_RLOAD, ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {AFT_CMD, AFT_WDATA, AFT_READ} ack_next_e;

  // strap: 0 ground, 1 supply, 2 data line, 3 clock line
  function automatic logic [6:0] strap_to_addr(input logic [1:0] strap);
    return {4'b0111, strap, 1'b0};
  endfunction

  function automatic logic [7:0] ptr_after(input logic [7:0] p);
    if (p == 8'h06) return 8'h00;
    if (p >= 8'h01 && p <= 8'h05) return p + 8'h01;
    return p;
  endfunction

  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      1: return 8'h0A;
      2: return 8'hFF;
      4: return 8'hFE;
      6: return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int idx);
    return (idx == 1) ? 8'hAB : 8'hFF;
  endfunction

endpackage

// File: rtl/kp_line_sync.sv
module kp_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic bus_edge
);
  logic [1:0] raw, synced, prev;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe    <= '1;
        prev[g] <= 1'b1;
      end else begin
        pipe    <= {pipe[STAGES-2:0], raw[g]};
        prev[g] <= pipe[STAGES-1];
      end
    end
    assign synced[g] = pipe[STAGES-1];
  end

  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
  assign bus_edge  = |(synced ^ prev);
endmodule

// File: rtl/kp_bus_timeout.sv
module kp_bus_timeout #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic active,
  input  logic activity,
  output logic fire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!active || activity) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign fire = enable && active && !activity && (cnt == LAST);
endmodule

// File: rtl/kp_target_fsm.sv
module kp_target_fsm
  import kp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       tmo_fire,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       pop,
  output logic       busy
);
  tgt_state_e st;
  ack_next_e  aft;
  logic [7:0] sh, tx;
  logic [2:0] cnt;
  logic [7:0] nbyte;

  assign nbyte = {sh[6:0], sda_s};
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; aft <= AFT_CMD; sh <= '0; tx <= '0; cnt <= '0;
      sda_oe <= 1'b0; ptr <= '0; wr_en <= 1'b0; wr_addr <= '0;
      wr_data <= '0; pop <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      pop   <= 1'b0;
      if (tmo_fire || stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            sh <= nbyte;
            if (cnt == 3'd7) begin
              if (nbyte[7:1] == dev_addr) begin
                aft <= nbyte[0] ? AFT_READ : AFT_CMD;
                st  <= ST_ACK_LO;
              end else st <= ST_IGNORE;
            end else cnt <= cnt + 3'd1;
          end
          ST_CMD: if (scl_rise) begin
            sh <= nbyte;
            if (cnt == 3'd7) begin
              ptr <= nbyte; aft <= AFT_WDATA; st <= ST_ACK_LO;
            end else cnt <= cnt + 3'd1;
          end
          ST_WDATA: if (scl_rise) begin
            sh <= nbyte;
            if (cnt == 3'd7) begin
              wr_en <= 1'b1; wr_addr <= ptr; wr_data <= nbyte;
              ptr <= ptr_after(ptr); st <= ST_ACK_LO;
            end else cnt <= cnt + 3'd1;
          end
          ST_ACK_LO: if (scl_fall) begin
            sda_oe <= 1'b1; st <= ST_ACK_HI;
          end
          ST_ACK_HI: if (scl_fall) begin
            cnt <= '0;
            case (aft)
              AFT_READ: begin
                tx <= rd_data; sda_oe <= ~rd_data[7]; st <= ST_RD;
              end
              AFT_CMD:  begin sda_oe <= 1'b0; st <= ST_CMD; end
              default:  begin sda_oe <= 1'b0; st <= ST_WDATA; end
            endcase
          end
          ST_RD: begin
            if (scl_rise) begin
              if (cnt == 3'd7) st <= ST_RD_END;
              else cnt <= cnt + 3'd1;
            end else if (scl_fall) begin
              tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6];
            end
          end
          ST_RD_END: if (scl_fall) begin
            sda_oe <= 1'b0; pop <= (ptr == 8'h00);
            ptr <= ptr_after(ptr); st <= ST_MACK;
          end
          ST_MACK: if (scl_rise) st <= sda_s ? ST_IGNORE : ST_RLOAD;
          ST_RLOAD: if (scl_fall) begin
            tx <= rd_data; sda_oe <= ~rd_data[7]; cnt <= '0; st <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop);
  // R7
  pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (ptr == 8'h00));
  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == ptr_after(wr_addr)));
  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (st == ST_IDLE && !sda_oe));
  // R8
  nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/kp_regfile.sv
module kp_regfile
  import kp_host_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [7:0]          rd_addr,
  input  logic [7:0]          evt_data,
  output logic [7:0]          rd_data,
  output logic [NREG-1:1][7:0] regs
);
  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= reg_reset(g);
      else if (wr_en && wr_addr == 8'(g)) regs[g] <= wr_data & reg_wmask(g);
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == 8'h00) rd_data = evt_data;
    for (int i = 1; i < NREG; i++)
      if (rd_addr == 8'(i)) rd_data = regs[i];
  end

  // R6
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[1] & 8'h54) == 8'h00);
  // R5
  ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'h00) |=> $stable(regs));
endmodule

// File: rtl/kp_host_if.sv
module kp_host_if
  import kp_host_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_i,
  input  logic [7:0] evt_data_i,
  output logic       evt_pop_o,
  output logic [7:0] cfg_o,
  output logic [7:0] dbnc_o,
  output logic [7:0] irq_o,
  output logic [7:0] port_o,
  output logic [7:0] rpt_o,
  output logic [7:0] sleep_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, bus_edge;
  logic tmo_fire, busy, wr_en;
  logic [7:0] ptr, wr_addr, wr_data, rd_data;
  logic [NREG-1:1][7:0] regs;

  kp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i, .scl_s, .sda_s, .scl_rise, .scl_fall,
    .start_det, .stop_det, .bus_edge
  );

  kp_bus_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk, .rst_n, .enable(~regs[1][0]), .active(busy), .activity(bus_edge),
    .fire(tmo_fire)
  );

  kp_target_fsm u_fsm (
    .clk, .rst_n, .sda_s, .scl_rise, .scl_fall, .start_det, .stop_det,
    .tmo_fire, .dev_addr(strap_to_addr(strap_i)), .rd_data,
    .sda_oe(sda_oe_o), .ptr, .wr_en, .wr_addr, .wr_data, .pop(evt_pop_o), .busy
  );

  kp_regfile u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr(ptr),
    .evt_data(evt_data_i), .rd_data, .regs
  );

  assign cfg_o   = regs[1];
  assign dbnc_o  = regs[2];
  assign irq_o   = regs[3];
  assign port_o  = regs[4];
  assign rpt_o   = regs[5];
  assign sleep_o = regs[6];

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe_o);
endmodule

// File: tb/test_kp_host_if.sv
module test_kp_host_if;
  localparam int Q = 10;
  localparam int TMO = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic sda_oe, evt_pop;
  logic [7:0] cfg, dbnc, irq, port, rpt, slp;
  logic [7:0] pop_cnt = 8'h00;
  wire  sda_line = sda_m & ~sda_oe;
  wire  [7:0] evt_data = 8'h80 + pop_cnt;

  int n_chk = 0, n_bad = 0;
  bit oe_seen = 1'b0, done = 1'b0;
  logic [7:0] mreg [1:6];

  always #10 clk = ~clk;

  kp_host_if #(.TIMEOUT_CYC(TMO)) i_kp_host_if (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .evt_data_i(evt_data),
    .evt_pop_o(evt_pop), .cfg_o(cfg), .dbnc_o(dbnc), .irq_o(irq),
    .port_o(port), .rpt_o(rpt), .sleep_o(slp)
  );

  always @(negedge clk) begin
    if (evt_pop) pop_cnt <= pop_cnt + 8'h01;
    if (sda_oe) oe_seen = 1'b1;
  end

  function automatic logic [7:0] step(input logic [7:0] p);
    if (p == 0) return 0;
    if (p < 6) return p + 1;
    if (p == 6) return 0;
    return p;
  endfunction

  function automatic logic [7:0] mval(input logic [7:0] p, input logic [7:0] d);
    return (p == 1) ? (d & ~8'h54) : d;
  endfunction

  function automatic logic [6:0] addr_of(input logic [1:0] s);
    return 7'h38 + 7'(2 * s);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(Q);
    r = sda_line; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, ack);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); b[i] = r; end
    bit_io(mack, r);
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input bit rnd, input logic [7:0] d0);
    logic a; logic [7:0] d;
    bus_start;
    send_byte({addr_of(strap), 1'b0}, a); chk("R1 addr ack", {7'd0, a}, 8'd0);
    send_byte(p, a); chk("R2 cmd ack", {7'd0, a}, 8'd0);
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : d0;
      send_byte(d, a); chk("R5 data ack", {7'd0, a}, 8'd0);
      if (p >= 1 && p <= 6) mreg[p] = mval(p, d);
      p = step(p);
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [7:0] p, input int n);
    logic a; logic [7:0] b, e, k;
    bus_start;
    send_byte({addr_of(strap), 1'b0}, a);
    send_byte(p, a);
    bus_start;
    send_byte({addr_of(strap), 1'b1}, a); chk("R9 restart ack", {7'd0, a}, 8'd0);
    k = pop_cnt;
    for (int i = 0; i < n; i++) begin
      if (p == 0) begin e = 8'h80 + k; k++; end
      else if (p <= 6) e = mreg[p];
      else e = 8'h00;
      recv_byte(i == n - 1, b);
      chk("R3 read data", b, e);
      p = step(p);
    end
    bus_stop;
    hold(2);
    chk("R7 pop count", pop_cnt, k);
  endtask

  task automatic check_outs;
    chk("R4 cfg", cfg, mreg[1]);   chk("R4 dbnc", dbnc, mreg[2]);
    chk("R4 irq", irq, mreg[3]);   chk("R4 port", port, mreg[4]);
    chk("R4 rpt", rpt, mreg[5]);   chk("R4 sleep", slp, mreg[6]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] b;
    void'($urandom(32'd1234));
    mreg[1] = 8'h0A; mreg[2] = 8'hFF; mreg[3] = 8'h00;
    mreg[4] = 8'hFE; mreg[5] = 8'h00; mreg[6] = 8'h07;
    hold(5); rst_n = 1'b1; hold(5);

    // R4 reset values at the ports and through reads (wraps to queue: R3)
    check_outs();
    chk("R4 sda idle", {7'd0, sda_oe}, 8'd0);
    do_read(8'h01, 7);
    do_read(8'h00, 1);

    // R1 every strap value
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      do_write(8'h04, 1, 1'b0, 8'h5A + 8'(s));
      check_outs();
      // R1 wrong address: no ack, no drive
      oe_seen = 1'b0;
      bus_start;
      send_byte({addr_of(2'(s + 1)), 1'b0}, a);
      chk("R1 foreign addr nack", {7'd0, a}, 8'd1);
      send_byte(8'h03, a);
      bus_stop;
      chk("R1 foreign no drive", {7'd0, oe_seen}, 8'd0);
    end

    // R6 reserved config bits
    do_write(8'h01, 1, 1'b0, 8'hFF);
    chk("R6 cfg reserved", cfg, 8'hAB);
    do_write(8'h01, 1, 1'b0, 8'h0A);

    // R5 write to queue location, pointer sticks at 0
    do_write(8'h00, 3, 1'b0, 8'h55);
    check_outs();
    do_read(8'h00, 3);

    // R7 no pop on other reads, R3 range above 6
    do_read(8'h03, 2);
    do_read(8'h09, 2);

    // R8 NACK then extra clocks
    bus_start;
    send_byte({addr_of(strap), 1'b0}, a); send_byte(8'h02, a);
    bus_start;
    send_byte({addr_of(strap), 1'b1}, a);
    recv_byte(1'b1, b); chk("R8 byte before nack", b, mreg[2]);
    oe_seen = 1'b0;
    recv_byte(1'b1, b);
    chk("R8 after nack released", b, 8'hFF);
    chk("R8 no drive", {7'd0, oe_seen}, 8'd0);
    bus_stop;

    // R9 bytes after STOP get no ack
    oe_seen = 1'b0;
    send_byte({addr_of(strap), 1'b0}, a);
    chk("R9 after stop nack", {7'd0, a}, 8'd1);
    bus_stop;

    // R10 timeout enabled (cfg bit0 = 0)
    bus_start;
    send_byte({addr_of(strap), 1'b0}, a);
    hold(TMO + 200);
    send_byte(8'h02, a);
    chk("R10 timeout idle", {7'd0, a}, 8'd1);
    bus_stop;
    // R10 timeout disabled (cfg bit0 = 1)
    do_write(8'h01, 1, 1'b0, 8'h0B);
    bus_start;
    send_byte({addr_of(strap), 1'b0}, a);
    hold(TMO + 200);
    send_byte(8'h02, a);
    chk("R10 disabled keeps txn", {7'd0, a}, 8'd0);
    bus_stop;

    // random traffic, R2 R3
    for (int it = 0; it < 20; it++) begin
      logic [7:0] p; int n;
      p = 8'(1 + $urandom % 6); n = 1 + int'($urandom % 4);
      do_write(p, n, 1'b1, 8'h00);
      check_outs();
      do_read(p, n + 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule